// File: doc/BRIEF.md
# Receive FIFO Idle Timeout Timer

This block watches the receive side of a serial port and raises a timeout status when received words sit in the receive FIFO with no further word arriving for a programmed number of bus clock cycles. Its purpose is to let software or a DMA engine collect the last few words of a transfer, which would otherwise stay below the receive service threshold.

The idle count is kept in bus clock cycles. Each word written into the receive FIFO restarts it. The timer only advances while the port is enabled and the FIFO holds data. After one expiry it stays quiet until a new word arrives and a complete new idle period passes. The status flag is sticky and is cleared by a write-one pulse. An interrupt output presents the flag only while its enable is set. All pins are plain control and status levels or strobes, so there is no valid/ready stream and no back-pressure.

Top module: `rx_idle_timeout`

## Requirements
- R1: After reset, `to_status` and `to_irq` are 0.
- R2: With `port_en`=1, `fifo_nonempty`=1 and `timeout_limit`=N (N>0), `to_status` becomes 1 after the Nth rising edge that follows the edge at which `word_push` was sampled 1, provided there is no new push in between. It is still 0 after the (N-1)th such edge.
- R3: A `word_push` sampled 1 restarts the idle count from zero, so a push that comes before expiry delays the timeout by a full new period.
- R4: While `fifo_nonempty`=0 and no push is present, the count is held at zero and the timer is disarmed. Data that becomes visible later without a new push never causes a timeout.
- R5: `timeout_limit`=0 disables the timer, and no timeout is raised for as long as it stays 0.
- R6: While `port_en`=0, the count is cleared and the timer is disarmed. Re-enabling the port without a new push raises no timeout.
- R7: One idle period produces at most one timeout. After expiry, no further timeout occurs until another push is followed by a full period.
- R8: `to_status` stays 1 until a cycle with `status_clr`=1 clears it at the next edge. If an expiry and a clear occur in the same cycle, the flag ends at 1.
- R9: `to_irq` is 1 exactly when `to_status`=1 and `irq_en`=1, and it follows `irq_en` in the same cycle.
- R10: If `timeout_limit` is lowered to a value at or below the idle cycles already counted, the timeout fires on the next counting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; the count unit |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable; timer counts only while 1 |
| word_push | input | 1 | Strobe: a word was written into the receive FIFO this cycle |
| fifo_nonempty | input | 1 | Receive FIFO holds at least one word |
| timeout_limit | input | TO_W (24) | Idle period in bus clock cycles; 0 disables |
| irq_en | input | 1 | Interrupt enable for the timeout status |
| status_clr | input | 1 | Write-one pulse clearing the timeout status |
| to_status | output | 1 | Sticky timeout status |
| to_irq | output | 1 | Timeout interrupt request |

## Verification
A count that is off by one shows up at the ports as a `to_status` rise one edge early or late relative to the push, and the directed timing checks detect it at that edge. An arm state that is not cleared on an empty FIFO, on disable or after expiry shows up as a spurious second rise, which appears a full period later, once the flag has been cleared. A flag that loses its stickiness or drops the set-over-clear priority is visible on the first cycle after the clear pulse. The random phase compares both outputs every cycle, so any divergence is reported within one period of its cause.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  parameter int unsigned DEF_TO_W = 24;

  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_WAIT = 1'b1
  } arm_state_e;
endpackage

// File: rtl/rxto_arm_ctrl.sv
module rxto_arm_ctrl
  import rxto_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic port_en,
  input  logic word_push,
  input  logic fifo_nonempty,
  input  logic expire,
  output logic armed
);
  arm_state_e state_q, state_d;

  // A push arms the timer; disable, an empty FIFO or an expiry disarms it.
  always_comb begin
    state_d = state_q;
    if (!port_en)            state_d = ARM_IDLE;
    else if (word_push)      state_d = ARM_WAIT;
    else if (!fifo_nonempty) state_d = ARM_IDLE;
    else if (expire)         state_d = ARM_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ARM_IDLE;
    else        state_q <= state_d;
  end

  assign armed = (state_q == ARM_WAIT);
endmodule

// File: rtl/rxto_idle_counter.sv
module rxto_idle_counter #(
  parameter int unsigned TO_W = rxto_pkg::DEF_TO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            armed,
  input  logic            port_en,
  input  logic            word_push,
  input  logic            fifo_nonempty,
  input  logic [TO_W-1:0] timeout_limit,
  output logic [TO_W-1:0] count,
  output logic            expire
);
  localparam logic [TO_W-1:0] ZERO = '0;

  logic [TO_W:0] cnt_inc;
  logic          limit_live;
  logic          idle_tick;
  logic          restart;

  assign cnt_inc    = {1'b0, count} + {{TO_W{1'b0}}, 1'b1};
  assign limit_live = (timeout_limit != ZERO);
  assign idle_tick  = armed && port_en && fifo_nonempty && !word_push && limit_live;
  // Greater-or-equal so a limit lowered mid-period still terminates it.
  assign expire     = idle_tick && (cnt_inc >= {1'b0, timeout_limit});
  assign restart    = !port_en || word_push || !fifo_nonempty || expire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         count <= ZERO;
    else if (restart)   count <= ZERO;
    else if (idle_tick) count <= cnt_inc[TO_W-1:0];
  end
endmodule

// File: rtl/rxto_sticky_flag.sv
module rxto_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout #(
  parameter int unsigned TO_W = rxto_pkg::DEF_TO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            port_en,
  input  logic            word_push,
  input  logic            fifo_nonempty,
  input  logic [TO_W-1:0] timeout_limit,
  input  logic            irq_en,
  input  logic            status_clr,
  output logic            to_status,
  output logic            to_irq
);
  logic            armed_w;
  logic            expire_w;
  logic [TO_W-1:0] count_w;

  rxto_arm_ctrl u_arm (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_en       (port_en),
    .word_push     (word_push),
    .fifo_nonempty (fifo_nonempty),
    .expire        (expire_w),
    .armed         (armed_w)
  );

  rxto_idle_counter #(.TO_W(TO_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .armed         (armed_w),
    .port_en       (port_en),
    .word_push     (word_push),
    .fifo_nonempty (fifo_nonempty),
    .timeout_limit (timeout_limit),
    .count         (count_w),
    .expire        (expire_w)
  );

  rxto_sticky_flag u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (expire_w),
    .clr   (status_clr),
    .flag  (to_status)
  );

  assign to_irq = to_status & irq_en;
endmodule

// File: rtl/rx_idle_timeout_checker.sv
module rx_idle_timeout_checker #(
  parameter int unsigned TO_W = rxto_pkg::DEF_TO_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic            port_en,
  input logic            word_push,
  input logic            fifo_nonempty,
  input logic [TO_W-1:0] timeout_limit,
  input logic            irq_en,
  input logic            status_clr,
  input logic            to_status,
  input logic            to_irq,
  input logic            expire_w,
  input logic [TO_W-1:0] count_w
);
  p_expire_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> to_status);
  p_push_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    word_push |=> (count_w == '0));
  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_nonempty |-> !expire_w);
  p_zero_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_limit == '0) |-> !expire_w);
  p_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !expire_w);
  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> !expire_w);
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (to_status && !status_clr) |=> to_status);
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_clr && !expire_w) |=> !to_status);
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !to_irq);
  p_irq_shown_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en && to_status) |-> to_irq);
  p_count_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expire_w |=> (count_w == '0));
endmodule

bind rx_idle_timeout rx_idle_timeout_checker #(.TO_W(TO_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .port_en       (port_en),
  .word_push     (word_push),
  .fifo_nonempty (fifo_nonempty),
  .timeout_limit (timeout_limit),
  .irq_en        (irq_en),
  .status_clr    (status_clr),
  .to_status     (to_status),
  .to_irq        (to_irq),
  .expire_w      (expire_w),
  .count_w       (count_w)
);

// File: tb/rx_idle_timeout_test.sv
`timescale 1ns/1ps
module rx_idle_timeout_test;
  localparam int unsigned TO_W = 24;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            port_en = 1'b0;
  logic            word_push = 1'b0;
  logic            fifo_nonempty = 1'b0;
  logic [TO_W-1:0] timeout_limit = '0;
  logic            irq_en = 1'b0;
  logic            status_clr = 1'b0;
  logic            to_status;
  logic            to_irq;

  int checks = 0;
  int fails = 0;

  // Bench model state, derived from the requirements
  int unsigned m_idle = 0;
  bit          m_arm = 1'b0;
  bit          m_flag = 1'b0;

  always #2.5 clk = ~clk;

  rx_idle_timeout #(.TO_W(TO_W)) uut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .word_push(word_push),
    .fifo_nonempty(fifo_nonempty), .timeout_limit(timeout_limit),
    .irq_en(irq_en), .status_clr(status_clr),
    .to_status(to_status), .to_irq(to_irq)
  );

  function automatic bit exp_irq(bit flag, bit en);
    return flag && en;
  endfunction

  function automatic bit idle_expired(int unsigned idle, int unsigned lim);
    return (lim != 0) && (idle >= lim);
  endfunction

  task automatic model_step();
    bit fire = 1'b0;
    if (!port_en)                      begin m_idle = 0; m_arm = 1'b0; end
    else if (word_push)                begin m_idle = 0; m_arm = 1'b1; end
    else if (!fifo_nonempty)           begin m_idle = 0; m_arm = 1'b0; end
    else if (m_arm && timeout_limit != 0) begin
      m_idle = m_idle + 1;
      if (idle_expired(m_idle, int'(timeout_limit))) begin
        fire = 1'b1; m_arm = 1'b0; m_idle = 0;
      end
    end
    if (fire) m_flag = 1'b1;
    else if (status_clr) m_flag = 1'b0;
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    #1;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_once();
    word_push = 1'b1; step(); word_push = 1'b0;
  endtask

  task automatic clear_flag();
    status_clr = 1'b1; step(); status_clr = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #12;
    check("R1 status", to_status, 1'b0);
    check("R1 irq", to_irq, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    port_en = 1'b1; fifo_nonempty = 1'b1; timeout_limit = 24'd5; irq_en = 1'b1;

    // R2: fires after the 5th idle edge, not the 4th
    push_once();
    steps(4);
    check("R2 before expiry", to_status, 1'b0);
    step();
    check("R2 at expiry", to_status, 1'b1);
    check("R9 irq enabled", to_irq, 1'b1);
    irq_en = 1'b0; #1;
    check("R9 irq masked", to_irq, 1'b0);
    irq_en = 1'b1; #1;
    check("R9 irq follows enable", to_irq, 1'b1);

    // R8: sticky, then cleared
    steps(6);
    check("R8 sticky", to_status, 1'b1);
    clear_flag();
    check("R8 cleared", to_status, 1'b0);

    // R7: no second timeout without a new push
    steps(20);
    check("R7 single fire", to_status, 1'b0);

    // R3: a push before expiry restarts the period
    push_once();
    steps(3);
    push_once();
    steps(4);
    check("R3 restarted not yet", to_status, 1'b0);
    step();
    check("R3 restarted expiry", to_status, 1'b1);
    clear_flag();

    // R4: empty FIFO holds and disarms
    push_once();
    fifo_nonempty = 1'b0;
    steps(10);
    check("R4 empty no fire", to_status, 1'b0);
    fifo_nonempty = 1'b1;
    steps(20);
    check("R4 refill without push", to_status, 1'b0);

    // R5: zero limit disables
    timeout_limit = '0;
    push_once();
    steps(50);
    check("R5 zero limit", to_status, 1'b0);
    timeout_limit = 24'd5;

    // R6: disable disarms
    push_once();
    port_en = 1'b0;
    steps(10);
    check("R6 disabled", to_status, 1'b0);
    port_en = 1'b1;
    steps(10);
    check("R6 re-enabled no push", to_status, 1'b0);

    // R10: lowered limit fires at the next counting edge
    timeout_limit = 24'd20;
    push_once();
    steps(8);
    check("R10 before lowering", to_status, 1'b0);
    timeout_limit = 24'd3;
    step();
    check("R10 lowered limit fires", to_status, 1'b1);
    clear_flag();

    // R8: set wins over a clear in the same cycle
    timeout_limit = 24'd4;
    push_once();
    steps(3);
    status_clr = 1'b1;
    step();
    status_clr = 1'b0;
    check("R8 set over clear", to_status, 1'b1);
    clear_flag();
    check("R8 clear after collision", to_status, 1'b0);

    // Random phase against the bench model (R2 R3 R4 R5 R6 R7 R8 R9 R10)
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom();
      word_push     = (r[2:0] == 3'd0);
      fifo_nonempty = (r[5:3] != 3'd0);
      port_en       = (r[10:6] != 5'd0);
      status_clr    = (r[14:11] == 4'd0);
      irq_en        = r[15];
      if (r[20:16] == 5'd0) timeout_limit = TO_W'(r[23:21]);
      step();
      check("R2-model status", to_status, m_flag);
      check("R9-model irq", to_irq, exp_irq(m_flag, irq_en));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule